// File: doc/BRIEF.md
# Register dependency hazard classifier

This block takes a window of decoded instructions, held in program order, and works out every data dependency and control dependency between them. Each slot in the window gives a destination register, two source registers and a flag that marks the slot as a conditional branch. The window is loaded in parallel with a one-cycle strobe. On the next clock edge the block registers one bit matrix for each data hazard class (read-after-write, write-after-read, write-after-write) and one vector that marks each slot sitting behind a branch.

Slot 0 is the oldest instruction. Bit `e*DEPTH + l` of a matrix describes the pair with earlier slot `e` and later slot `l`. Only bits with `e < l` can be set. A branch has no destination, so its destination field is ignored. Its two source fields are still treated as reads. The block only classifies hazards. A pipeline controller uses the matrices to decide on stalls or forwarding.

Top module: `hzc_classifier`

## Requirements
- R1: RAW bit `e*DEPTH+l` is set when e<l, slot e is not a branch, and the destination of slot e equals either source of slot l. A branch in slot l still counts as a reader.
- R2: WAR bit `e*DEPTH+l` is set when e<l, slot l is not a branch, and the destination of slot l equals either source of slot e.
- R3: WAW bit `e*DEPTH+l` is set when e<l, neither slot is a branch, and both destinations are equal.
- R4: Slots that only share source registers raise no flag in any matrix.
- R5: Control bit j (j>=1) is set exactly when slot j-1 is a branch. Bit 0 is always clear.
- R6: In every matrix, the bits on and below the diagonal (e >= l) are always zero.
- R7: The outputs are loaded on the clock edge where `load` is sampled high, and `done` is high for exactly the following cycle. Without a load, the outputs hold their values.
- R8: While reset is high, `done` and all matrix and control bits are zero.
- R9: The destination field of a branch slot has no effect: a branch never acts as a writer in R1, R2 or R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Window load strobe |
| win_dst | input | DEPTH*REG_W | Destination register of each slot, slot 0 in the low bits |
| win_src_a | input | DEPTH*REG_W | First source register of each slot |
| win_src_b | input | DEPTH*REG_W | Second source register of each slot |
| win_br | input | DEPTH | Branch flag of each slot |
| done | output | 1 | One-cycle pulse marking fresh results |
| raw_map | output | DEPTH*DEPTH | Read-after-write pair matrix |
| war_map | output | DEPTH*DEPTH | Write-after-read pair matrix |
| waw_map | output | DEPTH*DEPTH | Write-after-write pair matrix |
| ctrl_map | output | DEPTH | Slots following a branch |

## Verification
The assertions assume that `load` and the window fields are stable and known at each sampling edge. They also assume that reset is asserted from time zero, so the hold and pulse checks only ever compare against values the block registered itself. The bench changes inputs only on the falling clock edge and keeps register numbers in a narrow range, so random windows produce dense overlaps. It mixes back-to-back loads with idle gaps, and it writes garbage into branch destination fields to exercise the branch case.

// File: rtl/hzc_pkg.sv
package hzc_pkg;

    localparam int REG_W = 4;

    typedef logic [REG_W-1:0] reg_id_t;

    typedef struct packed {
        reg_id_t dst;
        reg_id_t src_a;
        reg_id_t src_b;
        logic    br;
    } slot_t;

    typedef struct packed {
        logic raw;
        logic war;
        logic waw;
    } pair_flags_t;

    function automatic logic slot_reads(slot_t s, reg_id_t r);
        return (s.src_a == r) || (s.src_b == r);
    endfunction

    function automatic logic slot_writes(slot_t s);
        return !s.br;
    endfunction

endpackage

// File: rtl/hzc_pair_cmp.sv
module hzc_pair_cmp
    import hzc_pkg::*;
(
    input  slot_t       early,
    input  slot_t       late,
    output pair_flags_t flags
);
    always_comb begin
        flags.raw = slot_writes(early) && slot_reads(late, early.dst);
        flags.war = slot_writes(late) && slot_reads(early, late.dst);
        flags.waw = slot_writes(early) && slot_writes(late) && (early.dst == late.dst);
    end
endmodule

// File: rtl/hzc_matrix.sv
module hzc_matrix
    import hzc_pkg::*;
#(
    parameter int DEPTH = 6
) (
    input  slot_t [DEPTH-1:0]       win,
    output logic  [DEPTH*DEPTH-1:0] raw_m,
    output logic  [DEPTH*DEPTH-1:0] war_m,
    output logic  [DEPTH*DEPTH-1:0] waw_m
);
    for (genvar e = 0; e < DEPTH; e++) begin : g_early
        for (genvar l = 0; l < DEPTH; l++) begin : g_late
            localparam int BIT = e * DEPTH + l;
            if (l > e) begin : g_pair
                pair_flags_t pf;
                hzc_pair_cmp u_cmp (
                    .early (win[e]),
                    .late  (win[l]),
                    .flags (pf)
                );
                assign raw_m[BIT] = pf.raw;
                assign war_m[BIT] = pf.war;
                assign waw_m[BIT] = pf.waw;
            end else begin : g_none
                assign raw_m[BIT] = 1'b0;
                assign war_m[BIT] = 1'b0;
                assign waw_m[BIT] = 1'b0;
            end
        end
    end
endmodule

// File: rtl/hzc_shadow.sv
module hzc_shadow #(
    parameter int DEPTH = 6
) (
    input  logic [DEPTH-1:0] br,
    output logic [DEPTH-1:0] shadow
);
    for (genvar j = 0; j < DEPTH; j++) begin : g_slot
        if (j == 0) begin : g_head
            assign shadow[j] = 1'b0;
        end else begin : g_tail
            assign shadow[j] = br[j-1];
        end
    end
endmodule

// File: rtl/hzc_classifier.sv
module hzc_classifier
    import hzc_pkg::*;
#(
    parameter int DEPTH = 6,
    localparam int RW   = hzc_pkg::REG_W,
    localparam int MW   = DEPTH * DEPTH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                load,
    input  logic [DEPTH*RW-1:0] win_dst,
    input  logic [DEPTH*RW-1:0] win_src_a,
    input  logic [DEPTH*RW-1:0] win_src_b,
    input  logic [DEPTH-1:0]    win_br,
    output logic                done,
    output logic [MW-1:0]       raw_map,
    output logic [MW-1:0]       war_map,
    output logic [MW-1:0]       waw_map,
    output logic [DEPTH-1:0]    ctrl_map
);
    slot_t [DEPTH-1:0] win;
    logic  [MW-1:0]    raw_n, war_n, waw_n;
    logic  [DEPTH-1:0] ctrl_n;

    always_comb begin
        for (int s = 0; s < DEPTH; s++) begin
            win[s].dst   = win_dst[s*RW +: RW];
            win[s].src_a = win_src_a[s*RW +: RW];
            win[s].src_b = win_src_b[s*RW +: RW];
            win[s].br    = win_br[s];
        end
    end

    hzc_matrix #(.DEPTH(DEPTH)) u_matrix (
        .win   (win),
        .raw_m (raw_n),
        .war_m (war_n),
        .waw_m (waw_n)
    );

    hzc_shadow #(.DEPTH(DEPTH)) u_shadow (
        .br     (win_br),
        .shadow (ctrl_n)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            done     <= 1'b0;
            raw_map  <= '0;
            war_map  <= '0;
            waw_map  <= '0;
            ctrl_map <= '0;
        end else begin
            done <= load;
            if (load) begin
                raw_map  <= raw_n;
                war_map  <= war_n;
                waw_map  <= waw_n;
                ctrl_map <= ctrl_n;
            end
        end
    end
endmodule

// File: rtl/hzc_classifier_chk.sv
module hzc_classifier_chk #(
    parameter int DEPTH = 6,
    parameter int RW    = 4,
    localparam int MW   = DEPTH * DEPTH
) (
    input logic                clk,
    input logic                rst,
    input logic                load,
    input logic [DEPTH*RW-1:0] win_dst,
    input logic [DEPTH*RW-1:0] win_src_a,
    input logic [DEPTH*RW-1:0] win_src_b,
    input logic [DEPTH-1:0]    win_br,
    input logic                done,
    input logic [MW-1:0]       raw_map,
    input logic [MW-1:0]       war_map,
    input logic [MW-1:0]       waw_map,
    input logic [DEPTH-1:0]    ctrl_map
);
    function automatic logic [MW-1:0] low_mask();
        logic [MW-1:0] m = '0;
        for (int e = 0; e < DEPTH; e++)
            for (int l = 0; l <= e; l++)
                m[e*DEPTH + l] = 1'b1;
        return m;
    endfunction

    localparam logic [MW-1:0] LOW = low_mask();

    p_done_after_load_r7: assert property (@(posedge clk) disable iff (rst)
        load |=> done);
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> !done);
    p_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !load |=> ($stable(raw_map) && $stable(war_map) && $stable(waw_map) && $stable(ctrl_map)));
    p_lower_empty_r6: assert property (@(posedge clk) disable iff (rst)
        ((raw_map & LOW) == '0) && ((war_map & LOW) == '0) && ((waw_map & LOW) == '0));
    p_first_clear_r5: assert property (@(posedge clk) disable iff (rst)
        ctrl_map[0] == 1'b0);
    p_reset_quiet_r8: assert property (@(posedge clk)
        rst |=> (!done && raw_map == '0 && war_map == '0 && waw_map == '0 && ctrl_map == '0));

    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        p_branch_no_write_r9: assert property (@(posedge clk) disable iff (rst)
            (load && win_br[i]) |=> (raw_map[i*DEPTH +: DEPTH] == '0 && waw_map[i*DEPTH +: DEPTH] == '0));
        if (i > 0) begin : g_sh
            p_shadow_follows_r5: assert property (@(posedge clk) disable iff (rst)
                load |=> (ctrl_map[i] == $past(win_br[i-1])));
        end
    end
endmodule

bind hzc_classifier hzc_classifier_chk #(.DEPTH(DEPTH), .RW(RW)) u_chk (.*);

// File: tb/hzc_classifier_tb.sv
module hzc_classifier_tb_top;
    localparam int D  = 6;
    localparam int RW = 4;
    localparam int MW = D * D;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            load = 1'b0;
    logic [D*RW-1:0] win_dst = '0, win_src_a = '0, win_src_b = '0;
    logic [D-1:0]    win_br = '0;
    logic            done;
    logic [MW-1:0]   raw_map, war_map, waw_map;
    logic [D-1:0]    ctrl_map;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    hzc_classifier #(.DEPTH(D)) dut_i (.*);

    always #5 clk = ~clk;

    // behavioural reference model
    logic [MW-1:0] e_raw = '0, e_war = '0, e_waw = '0;
    logic [D-1:0]  e_ctrl = '0;
    logic          e_done = 1'b0;

    always @(posedge clk) begin
        if (rst) begin
            e_raw = '0; e_war = '0; e_waw = '0; e_ctrl = '0; e_done = 1'b0;
        end else begin
            e_done = load;
            if (load) begin
                int dst[D], sa[D], sb[D];
                bit br[D];
                e_raw = '0; e_war = '0; e_waw = '0; e_ctrl = '0;
                for (int s = 0; s < D; s++) begin
                    dst[s] = int'(win_dst[s*RW +: RW]);
                    sa[s]  = int'(win_src_a[s*RW +: RW]);
                    sb[s]  = int'(win_src_b[s*RW +: RW]);
                    br[s]  = win_br[s];
                end
                for (int e = 0; e < D; e++) begin
                    for (int l = e + 1; l < D; l++) begin
                        if (!br[e] && (dst[e] == sa[l] || dst[e] == sb[l])) e_raw[e*D+l] = 1'b1;
                        if (!br[l] && (dst[l] == sa[e] || dst[l] == sb[e])) e_war[e*D+l] = 1'b1;
                        if (!br[e] && !br[l] && dst[e] == dst[l]) e_waw[e*D+l] = 1'b1;
                    end
                end
                for (int j = 1; j < D; j++) e_ctrl[j] = br[j-1];
            end
        end
    end

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // compare against the model every cycle
    always @(negedge clk) begin
        if (!finished) begin
            chk("R1 raw", 64'(raw_map), 64'(e_raw));
            chk("R2 war", 64'(war_map), 64'(e_war));
            chk("R3 waw", 64'(waw_map), 64'(e_waw));
            chk("R5 ctrl", 64'(ctrl_map), 64'(e_ctrl));
            chk("R7 done", 64'(done), 64'(e_done));
        end
    end

    function automatic logic [63:0] pb(int e, int l);
        return 64'd1 << (e * D + l);
    endfunction

    task automatic put(int s, int d, int a, int b, bit br);
        win_dst[s*RW +: RW]   = RW'(d);
        win_src_a[s*RW +: RW] = RW'(a);
        win_src_b[s*RW +: RW] = RW'(b);
        win_br[s]             = br;
    endtask

    task automatic pulse_load();
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    function automatic logic [63:0] upper();
        logic [63:0] m = '0;
        for (int e = 0; e < D; e++)
            for (int l = e + 1; l < D; l++) m |= pb(e, l);
        return m;
    endfunction

    initial begin
        #2_000_000;
        if (!finished) begin
            finished = 1;
            checks++; errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 done", 64'(done), 64'd0);
        chk("R8 raw", 64'(raw_map | war_map | waw_map), 64'd0);
        chk("R8 ctrl", 64'(ctrl_map), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        // classic six-instruction window; branch dst holds garbage (R9)
        put(0, 2, 5, 8, 0);
        put(1, 9, 2, 7, 0);
        put(2, 5, 14, 6, 0);
        put(3, 11, 9, 5, 0);
        put(4, 2, 10, 12, 1);
        put(5, 8, 15, 2, 0);
        pulse_load();
        chk("R7 done pulse", 64'(done), 64'd1);
        chk("R1 window", 64'(raw_map), pb(0,1) | pb(2,3) | pb(1,3) | pb(0,5));
        chk("R2 window", 64'(war_map), pb(0,2) | pb(0,5));
        chk("R3 window", 64'(waw_map), 64'd0);
        chk("R9 branch row", 64'(raw_map[4*D +: D]), 64'd0);
        chk("R5 window", 64'(ctrl_map), 64'(6'b100000));
        @(negedge clk);
        chk("R7 done clears", 64'(done), 64'd0);
        chk("R7 hold", 64'(raw_map), pb(0,1) | pb(2,3) | pb(1,3) | pb(0,5));

        // R4: only shared sources
        for (int s = 0; s < D; s++) put(s, 8 + s, 3, 3, 0);
        pulse_load();
        chk("R4 rar", 64'(raw_map | war_map | waw_map), 64'd0);

        // all same register: full upper triangle, never lower (R6)
        for (int s = 0; s < D; s++) put(s, 1, 1, 1, 0);
        pulse_load();
        chk("R1 full", 64'(raw_map), upper());
        chk("R2 full", 64'(war_map), upper());
        chk("R3 full", 64'(waw_map), upper());
        chk("R6 lower", 64'((raw_map | war_map | waw_map) & ~upper()), 64'd0);

        // branch in last slot: no follower; branch first: shadows slot 1
        for (int s = 0; s < D; s++) put(s, 1, 1, 1, (s == D-1) || (s == 0));
        pulse_load();
        chk("R5 edges", 64'(ctrl_map), 64'(6'b000010));
        chk("R9 waw", 64'(waw_map), upper() & ~(pb(0,1)|pb(0,2)|pb(0,3)|pb(0,4)|pb(0,5)
            |pb(1,5)|pb(2,5)|pb(3,5)|pb(4,5)));

        // random windows, back-to-back and gapped loads
        for (int n = 0; n < 400; n++) begin
            for (int s = 0; s < D; s++)
                put(s, $urandom_range(0,3), $urandom_range(0,3), $urandom_range(0,3),
                    ($urandom_range(0,3) == 0));
            load = ($urandom_range(0,2) != 0);
            @(negedge clk);
        end
        load = 1'b0;
        repeat (3) @(negedge clk);

        // R8: reset clears loaded state
        rst = 1'b1;
        @(negedge clk);
        chk("R8 reclear", 64'(raw_map | war_map | waw_map), 64'd0);
        rst = 1'b0;
        @(negedge clk);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule